// File: doc/BRIEF.md
# Masked Cross-Core Lookup-RAM Write Fabric

This block connects sixteen processor cores so that any core can push a word into the second write port of other cores' lookup RAMs. Each core keeps a target-select mask of sixteen bits, one per destination core, loaded by a strobe. A single write request from a core therefore lands in every core whose bit is set in the mask, including the sender's own RAM if its own bit is set. Every destination is fed by an AND-OR merge: the bundle of each writer (write strobe, 9-bit word address, 32-bit word) is gated by that writer's select bit for the destination, and all the gated bundles are ORed together.

Each request picks one of two modes. A fast request is placed on the merge path in the cycle after it is issued. It is not arbitrated, so two fast writers that reach the same destination in one cycle create one write whose address and data are the bitwise OR of theirs. A slotted request waits for the core's own slot of a free-running slot counter. Slots are one per core, so slotted writers can never share a cycle. A destination whose port is written gets a one-cycle event pulse in the cycle after the write commits.

The request side uses a valid/ready handshake per core. A request is taken in a cycle where both `req_valid` and `req_ready` are high. `req_ready` drops while a slotted request waits for its slot. During that time `req_valid`, mode, address and data are ignored, so a sender must hold its request until it sees ready again. The destination side has no back-pressure, because a RAM write port always accepts.

Top module: `lut_xwrite_fabric`

## Requirements
- R1: After reset, every select mask is zero, `req_ready` is all ones, and `lut_we`, `lut_event` and `req_done` are all zero.
- R2: A pulse on `mask_set[i]` loads `mask_val[i*16 +: 16]` as core i's select mask. A request uses the mask value held during its issue cycle, so a strobe affects requests issued from the next cycle onward. A request made with a zero mask writes nothing but still raises `req_done`.
- R3: A single request reaches every destination k whose select bit k is set, with the sender's address and data, and reaches no other destination.
- R4: A fast request (`req_slotted`=0) issued in cycle c shows on `lut_we`/`lut_addr`/`lut_wdata` of its destinations in cycle c+2, and its `req_done` pulses for one cycle in cycle c+2.
- R5: When several writers reach the same destination in one cycle, that destination sees one write whose address is the bitwise OR of their addresses and whose data is the bitwise OR of their data.
- R6: Writers whose masks select disjoint destinations in the same cycle do not change each other's writes.
- R7: A slotted request (`req_slotted`=1) from core i issued in cycle c is driven in the first cycle t > c where the slot count equals i. It shows at its destinations and on `req_done[i]` in cycle t+1, so completion takes 2 to 17 cycles. `req_ready[i]` is low in cycles c+1 through t. At most one slotted request is driven in any cycle.
- R8: The slot count is 0 in the first cycle after reset is released and increases by one each cycle, wrapping from 15 to 0.
- R9: `lut_event[k]` is high for exactly one cycle, one cycle after every cycle in which `lut_we[k]` is high, no matter how many writers merged into that write.
- R10: While `req_ready[i]` is low, `req_valid[i]` and the other request inputs of core i have no effect on any write port or on `req_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_set | input | 16 | Per-core strobe that loads the select mask |
| mask_val | input | 256 | Per-core new mask, core i in bits [i*16 +: 16] |
| req_valid | input | 16 | Per-core write request valid |
| req_slotted | input | 16 | Per-core mode: 1 slotted, 0 fast |
| req_addr | input | 144 | Per-core word address, core i in bits [i*9 +: 9] |
| req_data | input | 512 | Per-core write data, core i in bits [i*32 +: 32] |
| req_ready | output | 16 | Per-core request accept |
| req_done | output | 16 | Per-core one-cycle completion pulse |
| lut_we | output | 16 | Per-destination write strobe for the second RAM port |
| lut_addr | output | 144 | Per-destination write address, core k in bits [k*9 +: 9] |
| lut_wdata | output | 512 | Per-destination write data, core k in bits [k*32 +: 32] |
| lut_event | output | 16 | Per-destination one-cycle write event |

## Verification
Two things can fall on one destination in the same cycle: a fast write and a slotted write. They OR together just as two fast writes do. The bench provokes this by letting random fast requests run against slotted requests aimed at overlapping masks. It judges each cycle's merged address and data against a bench model that ORs every bundle it has scheduled for that cycle. A mask strobe can also share its cycle with a request from the same core. Directed and random stimulus both do this, and the model checks that the old mask governs that request while the new mask governs the next one.

// File: rtl/lxw_pkg.sv
package lxw_pkg;
  // request mode carried on req_slotted
  typedef enum logic {
    MODE_FAST = 1'b0,
    MODE_SLOT = 1'b1
  } wmode_e;

  // next value of a wrapping slot counter of a given depth
  function automatic int unsigned slot_next(int unsigned cur, int unsigned depth);
    return (cur == depth - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/lxw_slot_timer.sv
module lxw_slot_timer #(
  parameter int SLOTS = 16,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot_cnt
);
  import lxw_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_cnt <= '0;
    else        slot_cnt <= SW'(slot_next(int'(slot_cnt), SLOTS));
  end

  // R8
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_cnt != SW'(SLOTS - 1)) |=> (slot_cnt == $past(slot_cnt) + SW'(1)));
endmodule

// File: rtl/lxw_writer.sv
module lxw_writer #(
  parameter int N   = 16,
  parameter int AW  = 9,
  parameter int DW  = 32,
  parameter int IDX = 0,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] slot_cnt,
  input  logic          set_mask,
  input  logic [N-1:0]  mask_in,
  input  logic          valid,
  input  logic          mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          ready,
  output logic          done,
  output logic          drv,
  output logic          slot_drv,
  output logic [AW-1:0] drv_addr,
  output logic [DW-1:0] drv_data,
  output logic [N-1:0]  drv_mask
);
  import lxw_pkg::*;

  logic [N-1:0]  mask_q;
  logic          f_vld;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_data;
  logic [N-1:0]  f_mask;
  logic          s_pend;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;
  logic [N-1:0]  s_mask;
  logic          take;
  logic          slot_hit;

  assign ready    = !s_pend;
  assign take     = valid && ready;
  assign slot_hit = s_pend && (slot_cnt == SW'(IDX));

  // select mask register, sampled into a request at issue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '0;
    else if (set_mask) mask_q <= mask_in;
  end

  // fast stage: one register, drives the merge in the next cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_vld  <= 1'b0;
      f_addr <= '0;
      f_data <= '0;
      f_mask <= '0;
    end else begin
      f_vld <= take && (wmode_e'(mode) == MODE_FAST);
      if (take && (wmode_e'(mode) == MODE_FAST)) begin
        f_addr <= addr;
        f_data <= data;
        f_mask <= mask_q;
      end
    end
  end

  // slotted stage: holds until the slot counter reaches IDX
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_pend <= 1'b0;
      s_addr <= '0;
      s_data <= '0;
      s_mask <= '0;
    end else if (take && (wmode_e'(mode) == MODE_SLOT)) begin
      s_pend <= 1'b1;
      s_addr <= addr;
      s_data <= data;
      s_mask <= mask_q;
    end else if (slot_hit) begin
      s_pend <= 1'b0;
    end
  end

  // the two stages never drive together: ready is low while a slot waits
  assign drv      = f_vld || slot_hit;
  assign slot_drv = slot_hit;
  assign drv_addr = ({AW{f_vld}} & f_addr) | ({AW{slot_hit}} & s_addr);
  assign drv_data = ({DW{f_vld}} & f_data) | ({DW{slot_hit}} & s_data);
  assign drv_mask = ({N{f_vld}} & f_mask) | ({N{slot_hit}} & s_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= drv;
  end

  // R7
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && mode) |=> !ready);
  // R4
  fast_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !mode) |=> (drv && !slot_drv));
endmodule

// File: rtl/lxw_target_merge.sv
module lxw_target_merge #(
  parameter int N   = 16,
  parameter int AW  = 9,
  parameter int DW  = 32,
  parameter int TGT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    drv,
  input  logic [N*AW-1:0] drv_addr,
  input  logic [N*DW-1:0] drv_data,
  input  logic [N*N-1:0]  drv_mask,
  output logic            we,
  output logic [AW-1:0]   waddr,
  output logic [DW-1:0]   wdata,
  output logic            event_o
);
  logic          m_we;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;

  // AND each writer bundle with its select bit for this target, OR all
  always_comb begin
    m_we   = 1'b0;
    m_addr = '0;
    m_data = '0;
    for (int w = 0; w < N; w++) begin
      if (drv[w] && drv_mask[w*N + TGT]) begin
        m_we   = 1'b1;
        m_addr = m_addr | drv_addr[w*AW +: AW];
        m_data = m_data | drv_data[w*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we      <= 1'b0;
      waddr   <= '0;
      wdata   <= '0;
      event_o <= 1'b0;
    end else begin
      we      <= m_we;
      waddr   <= m_addr;
      wdata   <= m_data;
      event_o <= we;
    end
  end

  // R9
  ev_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> event_o);
  // R9
  ev_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(we));
endmodule

// File: rtl/lut_xwrite_fabric.sv
module lut_xwrite_fabric #(
  parameter int N  = 16,
  parameter int AW = 9,
  parameter int DW = 32,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    mask_set,
  input  logic [N*N-1:0]  mask_val,
  input  logic [N-1:0]    req_valid,
  input  logic [N-1:0]    req_slotted,
  input  logic [N*AW-1:0] req_addr,
  input  logic [N*DW-1:0] req_data,
  output logic [N-1:0]    req_ready,
  output logic [N-1:0]    req_done,
  output logic [N-1:0]    lut_we,
  output logic [N*AW-1:0] lut_addr,
  output logic [N*DW-1:0] lut_wdata,
  output logic [N-1:0]    lut_event
);
  logic [SW-1:0]   slot_cnt;
  logic [N-1:0]    drv;
  logic [N-1:0]    slot_drv;
  logic [N*AW-1:0] drv_addr;
  logic [N*DW-1:0] drv_data;
  logic [N*N-1:0]  drv_mask;

  lxw_slot_timer #(.SLOTS(N)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_cnt (slot_cnt)
  );

  for (genvar i = 0; i < N; i++) begin : g_wr
    lxw_writer #(.N(N), .AW(AW), .DW(DW), .IDX(i)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_cnt (slot_cnt),
      .set_mask (mask_set[i]),
      .mask_in  (mask_val[i*N +: N]),
      .valid    (req_valid[i]),
      .mode     (req_slotted[i]),
      .addr     (req_addr[i*AW +: AW]),
      .data     (req_data[i*DW +: DW]),
      .ready    (req_ready[i]),
      .done     (req_done[i]),
      .drv      (drv[i]),
      .slot_drv (slot_drv[i]),
      .drv_addr (drv_addr[i*AW +: AW]),
      .drv_data (drv_data[i*DW +: DW]),
      .drv_mask (drv_mask[i*N +: N])
    );
  end

  for (genvar k = 0; k < N; k++) begin : g_tg
    lxw_target_merge #(.N(N), .AW(AW), .DW(DW), .TGT(k)) u_tg (
      .clk      (clk),
      .rst_n    (rst_n),
      .drv      (drv),
      .drv_addr (drv_addr),
      .drv_data (drv_data),
      .drv_mask (drv_mask),
      .we       (lut_we[k]),
      .waddr    (lut_addr[k*AW +: AW]),
      .wdata    (lut_wdata[k*DW +: DW]),
      .event_o  (lut_event[k])
    );
  end

  // R7
  slot_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_drv));
  // R4
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv == '0) |=> (req_done == '0));
endmodule

// File: tb/lut_xwrite_fabric_test.sv
module lut_xwrite_fabric_test;
  localparam int N  = 16;
  localparam int AW = 9;
  localparam int DW = 32;
  localparam int RB = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    mask_set = '0;
  logic [N*N-1:0]  mask_val = '0;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_slotted = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_data = '0;
  logic [N-1:0]    req_ready;
  logic [N-1:0]    req_done;
  logic [N-1:0]    lut_we;
  logic [N*AW-1:0] lut_addr;
  logic [N*DW-1:0] lut_wdata;
  logic [N-1:0]    lut_event;

  lut_xwrite_fabric #(.N(N), .AW(AW), .DW(DW)) uut (.*);

  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit ended = 1'b0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // stimulus for the current cycle
  logic [N-1:0]  s_v, s_sl, s_set;
  logic [N-1:0]  s_mask [N];
  logic [AW-1:0] s_a [N];
  logic [DW-1:0] s_d [N];

  // reference model state
  logic [N-1:0]  mm [N];
  int            busy_until [N];
  logic [N-1:0]  e_en [RB];
  logic [N-1:0]  e_ev [RB];
  logic [N-1:0]  e_dn [RB];
  logic [AW-1:0] e_a [RB][N];
  logic [DW-1:0] e_d [RB][N];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_ready(int c);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (c > busy_until[i]);
    return r;
  endfunction

  // compare this cycle, drive this cycle, update model, advance
  task automatic run_cycle();
    int r;
    logic [N-1:0] rdy;
    r = cyc % RB;
    rdy = exp_ready(cyc);
    chk(req_ready == rdy, "R7 ready", 64'(req_ready), 64'(rdy));
    chk(lut_we == e_en[r], "R3 write strobes", 64'(lut_we), 64'(e_en[r]));
    chk(lut_event == e_ev[r], "R9 events", 64'(lut_event), 64'(e_ev[r]));
    chk(req_done == e_dn[r], "R4 done", 64'(req_done), 64'(e_dn[r]));
    for (int k = 0; k < N; k++) begin
      if (e_en[r][k] && lut_we[k]) begin
        chk(lut_addr[k*AW +: AW] == e_a[r][k], "R5 merged address",
            64'(lut_addr[k*AW +: AW]), 64'(e_a[r][k]));
        chk(lut_wdata[k*DW +: DW] == e_d[r][k], "R5 merged data",
            64'(lut_wdata[k*DW +: DW]), 64'(e_d[r][k]));
      end
    end
    e_en[r] = '0; e_ev[r] = '0; e_dn[r] = '0;
    for (int k = 0; k < N; k++) begin e_a[r][k] = '0; e_d[r][k] = '0; end
    // drive
    req_valid = s_v; req_slotted = s_sl; mask_set = s_set;
    for (int i = 0; i < N; i++) begin
      req_addr[i*AW +: AW] = s_a[i];
      req_data[i*DW +: DW] = s_d[i];
      mask_val[i*N +: N]   = s_mask[i];
    end
    // model: R2 uses mask held during issue; R10 ignores when not ready
    for (int i = 0; i < N; i++) begin
      if (s_v[i] && rdy[i]) begin
        int land, t;
        if (s_sl[i]) begin
          t = cyc + 1 + ((i - (cyc + 1)) % N + N) % N;   // R8 slot = cycle mod 16
          busy_until[i] = t;
          land = t + 1;
        end else begin
          land = cyc + 2;
        end
        e_dn[land % RB][i] = 1'b1;
        for (int k = 0; k < N; k++) begin
          if (mm[i][k]) begin
            e_en[land % RB][k] = 1'b1;
            e_ev[(land + 1) % RB][k] = 1'b1;
            e_a[land % RB][k] = e_a[land % RB][k] | s_a[i];
            e_d[land % RB][k] = e_d[land % RB][k] | s_d[i];
          end
        end
      end
      if (s_set[i]) mm[i] = s_mask[i];
    end
    s_v = '0; s_set = '0;
    for (int i = 0; i < N; i++) begin
      s_a[i] = 9'($urandom);
      s_d[i] = $urandom;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int j = 0; j < n; j++) run_cycle();
  endtask

  task automatic issue(int i, bit slotted, logic [AW-1:0] a, logic [DW-1:0] d);
    s_v[i] = 1'b1; s_sl[i] = slotted; s_a[i] = a; s_d[i] = d;
  endtask

  task automatic setm(int i, logic [N-1:0] m);
    s_set[i] = 1'b1; s_mask[i] = m;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    s_v = '0; s_sl = '0; s_set = '0;
    for (int i = 0; i < N; i++) begin
      mm[i] = '0; busy_until[i] = -1; s_mask[i] = '0; s_a[i] = '0; s_d[i] = '0;
    end
    for (int r = 0; r < RB; r++) begin
      e_en[r] = '0; e_ev[r] = '0; e_dn[r] = '0;
      for (int k = 0; k < N; k++) begin e_a[r][k] = '0; e_d[r][k] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(req_ready == '1, "R1 ready after reset", 64'(req_ready), 64'hFFFF);
    chk(lut_we == '0 && lut_event == '0 && req_done == '0, "R1 outputs idle",
        64'({lut_we, lut_event, req_done}), 64'd0);

    // R2: zero mask writes nothing; strobe in same cycle applies to the next one
    issue(3, 1'b0, 9'h011, 32'hDEAD_0001);
    setm(3, 16'h00F0);
    run_cycle();
    issue(3, 1'b0, 9'h022, 32'hDEAD_0002);
    idle(1); idle(6);
    // R3: one writer to several targets
    setm(5, 16'h8421); run_cycle();
    issue(5, 1'b0, 9'h1A5, 32'h1234_5678); idle(6);
    // R5: two fast writers on one target, OR merge
    setm(1, 16'h0200); setm(2, 16'h0200); run_cycle();
    issue(1, 1'b0, 9'h0A5, 32'h0F0F_0000); issue(2, 1'b0, 9'h150, 32'h0000_F0F1);
    idle(6);
    // R6: disjoint targets in the same cycle
    setm(1, 16'h0001); setm(2, 16'h0002); run_cycle();
    issue(1, 1'b0, 9'h003, 32'hAAAA_0000); issue(2, 1'b0, 9'h1FC, 32'h0000_5555);
    idle(6);
    // R7 / R8: two slotted writers to one target, no merge
    setm(4, 16'h0001); setm(11, 16'h0001); run_cycle();
    issue(4, 1'b1, 9'h0F0, 32'h4444_4444); issue(11, 1'b1, 9'h00F, 32'hBBBB_BBBB);
    run_cycle();
    // R10: hold a different request while busy, it must be ignored
    for (int j = 0; j < 20; j++) begin
      issue(11, 1'b0, 9'h1FF, 32'hFFFF_FFFF);
      run_cycle();
    end
    idle(20);

    // random mix, includes fast/slotted overlap on shared targets
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(0, 5) == 0)
          issue(i, 1'($urandom_range(0, 1)), 9'($urandom), $urandom);
        if ($urandom_range(0, 19) == 0)
          setm(i, ($urandom_range(0, 7) == 0) ? 16'h0000 : 16'($urandom) & 16'($urandom));
      end
      run_cycle();
    end
    idle(40);
    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog expired cycle=%0d actual=running expected=finished", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule